// File: doc/BRIEF.md
# Address-Latched Cartridge Bank Mapper

This block switches banks for a cartridge on an 8-bit game console. The CPU chooses banks by writing anywhere in the upper 32 KB of its address space. The value written on the data bus plays no part. Instead, the low twelve bits of the write address are captured into a single configuration latch. That latch holds the program-ROM block number, a 32 KB / 16 KB mode switch, a 16 KB half-select bit, a character-ROM bank field and a nametable mirroring bit.

The block widens the addresses in both directions. The CPU's 16-bit address becomes a 19-bit program-ROM address covering up to 512 KB. The 13-bit pattern-table address from the video side becomes an 18-bit character-ROM address. A single 8 KB character slot spans that whole window.

The parameter `CHR_VARIANT` picks the character-bank width:
- In variant 0 the bank is the 4-bit field alone, reaching 128 KB.
- In variant 1 address bit 6 is appended below the field as a fifth bit, reaching 256 KB.

Both ROM addresses are produced combinationally from the latch and the live bus addresses.

Top module: `addr_latch_mapper`

## Requirements
- R1: On a clock edge with `cpu_wr` high and `cpu_addr[15]` high and `rst_n` high, the latch takes `cpu_addr[11:0]`.
- R2: A write with `cpu_addr[15]` low changes none of the outputs.
- R3: With latched bit 4 clear (32 KB mode), the 16 KB bank is {latched bits 3:0, `cpu_addr[14]`}. `prg_rom_addr` is {bank, `cpu_addr[13:0]`}.
- R4: With latched bit 4 set (16 KB mode), the 16 KB bank is {latched bits 3:0, latched bit 5}. Both CPU halves, 0x8000 and 0xC000, see the same bank.
- R5: `mirror_horiz` equals latched bit 7: 1 means horizontal, 0 means vertical.
- R6: In variant 0, `chr_rom_addr` is {1'b0, latched bits 11:8, `ppu_addr`}, and latched bit 6 has no effect.
- R7: In variant 1, `chr_rom_addr` is {latched bits 11:8, latched bit 6, `ppu_addr`}.
- R8: A clock edge with `rst_n` low clears the latch, even if a write is present in that cycle. This gives bank 0 at 0x8000, bank 1 at 0xC000, character bank 0 and vertical mirroring.
- R9: In the cycle of a write, both ROM addresses are still formed from the previous latch contents. The new contents take effect right after the edge.
- R10: Write-address bits 14:12 are ignored. Only bit 15 qualifies the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wr | input | 1 | CPU write strobe, one per clock cycle |
| ppu_addr | input | 13 | Pattern-table address from the video side |
| prg_rom_addr | output | 19 | Program-ROM address |
| chr_rom_addr | output | 18 | Character-ROM address |
| mirror_horiz | output | 1 | Nametable mirroring: 1 horizontal, 0 vertical |

## Verification
Two functions can fall in the same cycle:
- A CPU write that reloads the latch.
- The program-address translation, which uses that same `cpu_addr`.

The bench provokes this by driving a write to 0xC003 and sampling `prg_rom_addr` before the edge. At that point the result must come from the old latch combined with the write address's own bit 14. After the edge the same address must map through the new bank.

Reset and a write also collide in one cycle. That case must leave the latch cleared.

// File: rtl/alm_pkg.sv
// Package: shared widths and the layout of the configuration latch.
// Assumes: the latch bit order mirrors write-address bits 11:0, since
// the register is loaded straight from the address bus.
package alm_pkg;

    localparam int CPU_AW      = 16;  // CPU address width
    localparam int PRG_BASE_W  = 4;   // 32 KB block selector width
    localparam int CHR_FIELD_W = 4;   // character bank field width
    localparam int PRG_OFS_W   = 14;  // offset inside a 16 KB bank
    localparam int CHR_OFS_W   = 13;  // offset inside an 8 KB bank
    localparam int LATCH_W     = CHR_FIELD_W + 4 + PRG_BASE_W;
    localparam int PRG_AW      = PRG_BASE_W + 1 + PRG_OFS_W;
    localparam int CHR_AW      = CHR_FIELD_W + 1 + CHR_OFS_W;

    typedef struct packed {
        logic [CHR_FIELD_W-1:0] chr_field;  // addr 11:8
        logic                   mirror_h;   // addr 7
        logic                   chr_lsb;    // addr 6
        logic                   sub16;      // addr 5
        logic                   mode16;     // addr 4
        logic [PRG_BASE_W-1:0]  prg_base;   // addr 3:0
    } latch_t;

endpackage

// File: rtl/alm_latch.sv
// Module: configuration latch.
// Captures the low address bits when a qualified write arrives.
// Assumes: load_en is already qualified by the window decode.
//          Reset is synchronous and takes priority over a load.
module alm_latch
    import alm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [LATCH_W-1:0] addr_lo,
    output latch_t             q
);

    // Hold the configuration; clear on reset, reload on a window write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load_en) begin
            q <= latch_t'(addr_lo);
        end
    end

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (q == latch_t'('0)));

endmodule

// File: rtl/alm_prg_map.sv
// Module: program-ROM address translation.
// Assumes: cpu_a14 and cpu_ofs come from the live CPU address.
// 32 KB mode lets CPU bit 14 pick the half.
// 16 KB mode forces the half from the latched sub-bank bit.
module alm_prg_map
    import alm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PRG_BASE_W-1:0] prg_base,
    input  logic                  mode16,
    input  logic                  sub16,
    input  logic                  cpu_a14,
    input  logic [PRG_OFS_W-1:0]  cpu_ofs,
    output logic [PRG_AW-1:0]     prg_rom_addr
);

    logic half_sel;

    // Pick the 16 KB half: latched bit in 16 KB mode, CPU bit otherwise.
    always_comb begin
        half_sel = mode16 ? sub16 : cpu_a14;
    end

    // Join block, half and offset into the ROM address.
    always_comb begin
        prg_rom_addr = {prg_base, half_sel, cpu_ofs};
    end

    // R4
    half_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode16 |-> (prg_rom_addr[PRG_OFS_W] == sub16));

    // R3
    half_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode16 |-> (prg_rom_addr[PRG_OFS_W] == cpu_a14));

endmodule

// File: rtl/alm_chr_map.sv
// Module: character-ROM address translation.
// Assumes: one 8 KB slot covers the whole pattern-table window.
// VARIANT 0: the bank is the 4-bit field; the top bit is tied low.
// VARIANT 1: the latched bit 6 is appended below the field.
module alm_chr_map
    import alm_pkg::*;
#(
    parameter int VARIANT = 0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CHR_FIELD_W-1:0] chr_field,
    input  logic                   chr_lsb,
    input  logic [CHR_OFS_W-1:0]   ppu_addr,
    output logic [CHR_AW-1:0]      chr_rom_addr
);

    generate
        if (VARIANT == 1) begin : g_wide
            // Five-bit bank: field above the extra low bit.
            always_comb begin
                chr_rom_addr = {chr_field, chr_lsb, ppu_addr};
            end
        end else begin : g_narrow
            // Four-bit bank; the extra bit is ignored.
            always_comb begin
                chr_rom_addr = {1'b0, chr_field, ppu_addr};
            end

            // R6
            lsb_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (chr_lsb != $past(chr_lsb)) && $stable(chr_field) && $stable(ppu_addr)
                |-> $stable(chr_rom_addr));
        end
    endgenerate

endmodule

// File: rtl/addr_latch_mapper.sv
// Module: address-latched cartridge bank mapper (top).
// Decodes writes into the upper 32 KB window and latches address bits 11:0.
// Drives the program and character ROM addresses and the mirroring select.
// Assumes: one write strobe per cycle, synchronous active-low reset.
//          The data bus is not an input.
module addr_latch_mapper
    import alm_pkg::*;
#(
    parameter int CHR_VARIANT = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CPU_AW-1:0]    cpu_addr,
    input  logic                 cpu_wr,
    input  logic [CHR_OFS_W-1:0] ppu_addr,
    output logic [PRG_AW-1:0]    prg_rom_addr,
    output logic [CHR_AW-1:0]    chr_rom_addr,
    output logic                 mirror_horiz
);

    latch_t q;
    logic   win_wr;

    // Qualify a write by the top address bit alone.
    always_comb begin
        win_wr = cpu_wr & cpu_addr[CPU_AW-1];
    end

    alm_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (win_wr),
        .addr_lo (cpu_addr[LATCH_W-1:0]),
        .q       (q)
    );

    alm_prg_map u_prg (
        .clk          (clk),
        .rst_n        (rst_n),
        .prg_base     (q.prg_base),
        .mode16       (q.mode16),
        .sub16        (q.sub16),
        .cpu_a14      (cpu_addr[PRG_OFS_W]),
        .cpu_ofs      (cpu_addr[PRG_OFS_W-1:0]),
        .prg_rom_addr (prg_rom_addr)
    );

    alm_chr_map #(.VARIANT(CHR_VARIANT)) u_chr (
        .clk          (clk),
        .rst_n        (rst_n),
        .chr_field    (q.chr_field),
        .chr_lsb      (q.chr_lsb),
        .ppu_addr     (ppu_addr),
        .chr_rom_addr (chr_rom_addr)
    );

    // Mirroring select comes straight from its latched bit.
    always_comb begin
        mirror_horiz = q.mirror_h;
    end

    // R1
    load_from_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[CPU_AW-1]) |=> (q == latch_t'($past(cpu_addr[LATCH_W-1:0]))));

    // R2
    low_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_addr[CPU_AW-1]) |=> ($stable(q) && $stable(mirror_horiz)));

endmodule

// File: tb/addr_latch_mapper_tb.sv
module addr_latch_mapper_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_wr = 1'b0;
    logic [12:0] ppu_addr = 13'h0000;
    logic [18:0] prg0, prg1;
    logic [17:0] chr0, chr1;
    logic        mir0, mir1;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    addr_latch_mapper #(.CHR_VARIANT(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .ppu_addr(ppu_addr), .prg_rom_addr(prg0), .chr_rom_addr(chr0),
        .mirror_horiz(mir0)
    );

    addr_latch_mapper #(.CHR_VARIANT(1)) u_dut_v1 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .ppu_addr(ppu_addr), .prg_rom_addr(prg1), .chr_rom_addr(chr1),
        .mirror_horiz(mir1)
    );

    // Vector table: write address, read address, pattern address, expected values.
    localparam int NV = 8;
    localparam logic [15:0] V_WR  [NV] = '{16'h8003, 16'h8003, 16'h8010, 16'h8240,
                                           16'h8080, 16'hFFFF, 16'h8F30, 16'h9A2C};
    localparam logic [15:0] V_RD  [NV] = '{16'h8000, 16'hC000, 16'hC123, 16'h8000,
                                           16'h8000, 16'h8005, 16'hE001, 16'hC000};
    localparam logic [12:0] V_PPU [NV] = '{13'h0000, 13'h0000, 13'h0000, 13'h1ABC,
                                           13'h0000, 13'h1FFF, 13'h0010, 13'h0800};
    localparam logic [18:0] V_PRG [NV] = '{19'h18000, 19'h1C000, 19'h00123, 19'h00000,
                                           19'h00000, 19'h7C005, 19'h06001, 19'h64000};
    localparam logic [17:0] V_C0  [NV] = '{18'h00000, 18'h00000, 18'h00000, 18'h05ABC,
                                           18'h00000, 18'h1FFFF, 18'h1E010, 18'h14800};
    localparam logic [17:0] V_C1  [NV] = '{18'h00000, 18'h00000, 18'h00000, 18'h0BABC,
                                           18'h00000, 18'h3FFFF, 18'h3C010, 18'h28800};
    localparam logic        V_MIR [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam logic [15:0] V_TAG [NV] = '{"R3", "R3", "R4", "R7", "R5", "R4", "R6", "R10"};

    task automatic chk(input logic [15:0] tag, input logic [19:0] act, input logic [19:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a;
        cpu_wr   = 1'b1;
        @(negedge clk);
        cpu_wr   = 1'b0;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state, bank 0 low half, bank 1 high half, vertical
        cpu_addr = 16'h8000; #1;
        chk("R8", 20'(prg0), 20'h00000);
        cpu_addr = 16'hC000; #1;
        chk("R8", 20'(prg0), 20'h04000);
        chk("R8", 20'(chr0), 20'h0);
        chk("R8", 20'(chr1), 20'h0);
        chk("R8", 20'(mir0), 20'h0);

        // Table walk (R1 through every load)
        for (int i = 0; i < NV; i++) begin
            do_write(V_WR[i]);
            cpu_addr = V_RD[i];
            ppu_addr = V_PPU[i];
            #1;
            chk(V_TAG[i], 20'(prg0), 20'(V_PRG[i]));
            chk(V_TAG[i], 20'(prg1), 20'(V_PRG[i]));
            chk(V_TAG[i], 20'(chr0), 20'(V_C0[i]));
            chk(V_TAG[i], 20'(chr1), 20'(V_C1[i]));
            chk(V_TAG[i], 20'(mir0), 20'(V_MIR[i]));
            chk("R1", 20'(mir1), 20'(V_MIR[i]));
        end

        // R8: reset wins over a write in the same cycle
        @(negedge clk);
        rst_n = 1'b0; cpu_wr = 1'b1; cpu_addr = 16'hFFFF;
        @(negedge clk);
        rst_n = 1'b1; cpu_wr = 1'b0; cpu_addr = 16'hC000; ppu_addr = 13'h0000;
        #1;
        chk("R8", 20'(prg0), 20'h04000);
        chk("R8", 20'(chr1), 20'h0);
        chk("R8", 20'(mir1), 20'h0);

        // R9: write cycle still uses old latch with the write address bit 14
        @(negedge clk);
        cpu_addr = 16'hC003; cpu_wr = 1'b1;
        #1;
        chk("R9", 20'(prg0), 20'h04003);
        @(negedge clk);
        cpu_wr = 1'b0;
        #1;
        chk("R9", 20'(prg0), 20'h1C003);

        // R2: write below the window leaves every output as it was
        do_write(16'h7FFF);
        cpu_addr = 16'hC003; ppu_addr = 13'h0000;
        #1;
        chk("R2", 20'(prg0), 20'h1C003);
        chk("R2", 20'(chr1), 20'h0);
        chk("R2", 20'(mir0), 20'h0);

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a miscompare.
    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

endmodule